// File: doc/BRIEF.md
# Segment Register File with Effective Base

This block holds the segment state of one processor thread. It has thirteen slots, and each slot keeps five values: a selector, an architectural base, an effective base, a limit and an attributes word. Microcode writes the selector, base, limit and attributes through four independent indexed write ports. Each port has its own enable, index and data, so a single cycle can update several fields at once. A combinational read port returns the four architectural fields of one slot. A second combinational port returns the effective base of a slot, and address generation uses that port.

The block keeps the effective base in step with the architectural base, and the rule depends on the slot. Some slots always copy the base into the effective base. The four legacy data and code slots do the copy only when the core is outside 64-bit mode. The flat slot always reads as base zero. The emulation slot keeps an effective base of zero.

Top module: `seg_regfile`

## Requirements
- R1: Slot indices are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5, temporary=6, local table=7, global table=8, flat=9, emulation=10, task=11, interrupt table=12. A write with its enable high stores into the indexed slot at the clock edge. The stored value is visible on the read port from the next cycle.
- R2: The flat slot (index 9) always reads base 0 and effective base 0. Base writes to it have no effect.
- R3: For indices 4, 5, 6, 7, 8, 11 and 12, a base write also sets the effective base to the written value, which is visible on `eff_base` in the next cycle.
- R4: For indices 0 to 3, a base write updates the effective base only when `long_mode_act` is 0 or bit `LONG_ATTR_BIT` of the CS attributes is 0. Both values are taken as they stand before the clock edge, so a CS attribute write in the same cycle does not yet count.
- R5: In 64-bit mode, a base write to indices 0 to 3 leaves the effective base at its previous value. That value is 0 if the slot has had no earlier update.
- R6: A base write to the emulation slot (index 10) changes its base but leaves its effective base at 0.
- R7: After reset, every field of every slot is 0, except the limits of the local table, global table and interrupt table slots, which are 0xFFFF.
- R8: Writes to different fields of the same slot in one cycle are all applied.
- R9: A read in the same cycle as a write to that slot returns the value from before the write.
- R10: Writes to an index of 13 to 15 change no slot. Reads of such an index return 0 on both read ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| long_mode_act | input | 1 | Long mode is active |
| sel_we | input | 1 | Selector write enable |
| sel_widx | input | 4 | Selector write slot index |
| sel_wdata | input | SEL_W | Selector write data |
| base_we | input | 1 | Base write enable |
| base_widx | input | 4 | Base write slot index |
| base_wdata | input | BASE_W | Base write data |
| lim_we | input | 1 | Limit write enable |
| lim_widx | input | 4 | Limit write slot index |
| lim_wdata | input | LIM_W | Limit write data |
| attr_we | input | 1 | Attributes write enable |
| attr_widx | input | 4 | Attributes write slot index |
| attr_wdata | input | ATTR_W | Attributes write data |
| rd_idx | input | 4 | Read slot index |
| rd_sel | output | SEL_W | Selector of the read slot |
| rd_base | output | BASE_W | Architectural base of the read slot |
| rd_lim | output | LIM_W | Limit of the read slot |
| rd_attr | output | ATTR_W | Attributes of the read slot |
| eff_idx | input | 4 | Effective-base read slot index |
| eff_base | output | BASE_W | Effective base of the selected slot |

## Verification
The bench builds the block with `BASE_W` = 40 and `LONG_ATTR_BIT` = 3, and keeps the default selector, limit and attribute widths. A base narrower than 64 bits shows that the policy logic does not assume a fixed width. Moving the long-mode bit to position 3 lets small attribute values switch the core into and out of 64-bit mode. With these settings, one short run can cover every combination of the long-mode input and the CS attribute bit. It also covers the case where a CS attribute write and a legacy base write land in the same cycle.

// File: rtl/seg_pkg.sv
// Shared definitions for the segment register file.
// Assumes thirteen slots; the slot order is fixed because the
// effective-base policy is keyed on the index.
package seg_pkg;

    localparam int NUM_SEG   = 13;
    localparam int SEG_IDX_W = $clog2(NUM_SEG);

    typedef enum logic [SEG_IDX_W-1:0] {
        SEG_ES   = 4'd0,
        SEG_CS   = 4'd1,
        SEG_SS   = 4'd2,
        SEG_DS   = 4'd3,
        SEG_FS   = 4'd4,
        SEG_GS   = 4'd5,
        SEG_TMP  = 4'd6,
        SEG_LTAB = 4'd7,
        SEG_GTAB = 4'd8,
        SEG_FLAT = 4'd9,
        SEG_EMU  = 4'd10,
        SEG_TASK = 4'd11,
        SEG_ITAB = 4'd12
    } seg_idx_e;

    // How a base write affects the effective base of a slot.
    typedef enum logic [1:0] {
        EB_ALWAYS,   // copy on every base write
        EB_LEGACY,   // copy only outside 64-bit mode
        EB_NEVER,    // effective base stays at zero
        EB_ZERO      // base and effective base both pinned to zero
    } eb_policy_e;

    // Maps a slot index to its effective-base policy.
    function automatic eb_policy_e eb_policy(input logic [SEG_IDX_W-1:0] idx);
        case (idx)
            SEG_ES, SEG_CS, SEG_SS, SEG_DS:            return EB_LEGACY;
            SEG_FS, SEG_GS, SEG_TMP, SEG_LTAB,
            SEG_GTAB, SEG_TASK, SEG_ITAB:              return EB_ALWAYS;
            SEG_FLAT:                                  return EB_ZERO;
            default:                                   return EB_NEVER;
        endcase
    endfunction

    // Slots whose limit resets to the all-ones 16-bit value.
    localparam logic [NUM_SEG-1:0] LIM_RST_MASK =
        NUM_SEG'((1 << SEG_LTAB) | (1 << SEG_GTAB) | (1 << SEG_ITAB));

endpackage

// File: rtl/seg_field_bank.sv
// One field (selector, limit or attributes) for every slot.
// Has one indexed write port and one combinational read port.
// Assumes an index at or above N selects no slot: writes drop and reads give 0.
module seg_field_bank #(
    parameter int              W        = 16,
    parameter int              N        = 13,
    parameter int              IW       = 4,
    parameter logic [N-1:0]    RST_MASK = '0,
    parameter logic [W-1:0]    RST_VAL  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);

    logic [W-1:0]   q [N];
    logic [N*W-1:0] q_flat;

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Holds one slot's field; loads on an indexed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g] <= RST_MASK[g] ? RST_VAL : '0;
            else if (we && widx == IW'(g))
                q[g] <= wdata;
        end
        assign q_flat[g*W +: W] = q[g];
    end

    // Selects the addressed slot, returning zero for indices out of range.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (ridx == IW'(i)) rdata = q[i];
    end

    a_r1_field_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx < IW'(N)) |=> q[$past(widx)] == $past(wdata));

    a_r10_oob_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx >= IW'(N)) |=> q_flat == $past(q_flat));

endmodule

// File: rtl/seg_base_bank.sv
// Architectural base and effective base for every slot.
// The effective base follows base writes according to each slot's policy.
// Assumes legacy_ok is computed before the edge from state that has not yet been updated.
module seg_base_bank
    import seg_pkg::*;
#(
    parameter int W  = 64,
    parameter int N  = NUM_SEG,
    parameter int IW = SEG_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic          legacy_ok,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata,
    input  logic [IW-1:0] eidx,
    output logic [W-1:0]  edata
);

    logic [W-1:0] base_q [N];
    logic [W-1:0] eff_q  [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        localparam eb_policy_e POL = eb_policy(IW'(g));
        logic hit;
        assign hit = we && widx == IW'(g);

        // Architectural base; the flat slot never loads.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_q[g] <= '0;
            else if (hit && POL != EB_ZERO)
                base_q[g] <= wdata;
        end

        // Effective base; loads per the slot policy.
        always_ff @(posedge clk) begin
            if (!rst_n)
                eff_q[g] <= '0;
            else if (hit && (POL == EB_ALWAYS || (POL == EB_LEGACY && legacy_ok)))
                eff_q[g] <= wdata;
        end
    end

    // Read mux for the architectural base.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++)
            if (ridx == IW'(i)) rdata = base_q[i];
    end

    // Read mux for the effective base used by address generation.
    always_comb begin
        edata = '0;
        for (int i = 0; i < N; i++)
            if (eidx == IW'(i)) edata = eff_q[i];
    end

    a_r3_eff_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (we && eb_policy(widx) == EB_ALWAYS) |=> eff_q[$past(widx)] == $past(wdata));

    a_r4_legacy_update: assert property (@(posedge clk) disable iff (!rst_n)
        (we && eb_policy(widx) == EB_LEGACY && legacy_ok)
        |=> eff_q[$past(widx)] == $past(wdata));

    a_r5_legacy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (we && eb_policy(widx) == EB_LEGACY && !legacy_ok)
        |=> eff_q[$past(widx)] == $past(eff_q[widx]));

    a_r2_flat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx == SEG_FLAT) |=> base_q[SEG_FLAT] == '0 && eff_q[SEG_FLAT] == '0);

    a_r6_emu_eff_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (we && widx == SEG_EMU) |=> eff_q[SEG_EMU] == '0);

endmodule

// File: rtl/seg_regfile.sv
// Segment register file: thirteen slots, each with a selector, base,
// effective base, limit and attributes, plus indexed write and read ports.
// Decides 64-bit mode from the long-mode input and a shadow copy of the
// CS long-mode attribute bit.
// Assumes LONG_ATTR_BIT < ATTR_W and LIM_W >= 16.
module seg_regfile
    import seg_pkg::*;
#(
    parameter int SEL_W         = 16,
    parameter int BASE_W        = 64,
    parameter int LIM_W         = 32,
    parameter int ATTR_W        = 16,
    parameter int LONG_ATTR_BIT = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 long_mode_act,
    input  logic                 sel_we,
    input  logic [SEG_IDX_W-1:0] sel_widx,
    input  logic [SEL_W-1:0]     sel_wdata,
    input  logic                 base_we,
    input  logic [SEG_IDX_W-1:0] base_widx,
    input  logic [BASE_W-1:0]    base_wdata,
    input  logic                 lim_we,
    input  logic [SEG_IDX_W-1:0] lim_widx,
    input  logic [LIM_W-1:0]     lim_wdata,
    input  logic                 attr_we,
    input  logic [SEG_IDX_W-1:0] attr_widx,
    input  logic [ATTR_W-1:0]    attr_wdata,
    input  logic [SEG_IDX_W-1:0] rd_idx,
    output logic [SEL_W-1:0]     rd_sel,
    output logic [BASE_W-1:0]    rd_base,
    output logic [LIM_W-1:0]     rd_lim,
    output logic [ATTR_W-1:0]    rd_attr,
    input  logic [SEG_IDX_W-1:0] eff_idx,
    output logic [BASE_W-1:0]    eff_base
);

    localparam logic [LIM_W-1:0] LIM_RST = LIM_W'(32'h0000_FFFF);

    logic cs_long_q;
    logic legacy_ok;

    // Shadow of the CS long-mode attribute bit, kept so the mode is known without a read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cs_long_q <= 1'b0;
        else if (attr_we && attr_widx == SEG_CS)
            cs_long_q <= attr_wdata[LONG_ATTR_BIT];
    end

    // Outside 64-bit mode unless long mode and the CS long bit are both set.
    assign legacy_ok = !(long_mode_act && cs_long_q);

    seg_field_bank #(.W(SEL_W), .N(NUM_SEG), .IW(SEG_IDX_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .we(sel_we), .widx(sel_widx),
        .wdata(sel_wdata), .ridx(rd_idx), .rdata(rd_sel));

    seg_field_bank #(.W(LIM_W), .N(NUM_SEG), .IW(SEG_IDX_W),
                     .RST_MASK(LIM_RST_MASK), .RST_VAL(LIM_RST)) u_lim (
        .clk(clk), .rst_n(rst_n), .we(lim_we), .widx(lim_widx),
        .wdata(lim_wdata), .ridx(rd_idx), .rdata(rd_lim));

    seg_field_bank #(.W(ATTR_W), .N(NUM_SEG), .IW(SEG_IDX_W)) u_attr (
        .clk(clk), .rst_n(rst_n), .we(attr_we), .widx(attr_widx),
        .wdata(attr_wdata), .ridx(rd_idx), .rdata(rd_attr));

    seg_base_bank #(.W(BASE_W), .N(NUM_SEG), .IW(SEG_IDX_W)) u_base (
        .clk(clk), .rst_n(rst_n), .we(base_we), .widx(base_widx),
        .wdata(base_wdata), .legacy_ok(legacy_ok),
        .ridx(rd_idx), .rdata(rd_base), .eidx(eff_idx), .edata(eff_base));

    a_r4_shadow_tracks_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_we && attr_widx == SEG_CS) |=> cs_long_q == $past(attr_wdata[LONG_ATTR_BIT]));

    a_r10_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= SEG_IDX_W'(NUM_SEG)) |-> (rd_sel == '0 && rd_lim == '0 && rd_attr == '0 && rd_base == '0));

endmodule

// File: tb/tb_seg_regfile.sv
// Scoreboard bench: driver tasks push expected read values, a monitor compares at the falling edge.
module tb_seg_regfile;

    localparam int SEL_W = 16, BASE_W = 40, LIM_W = 32, ATTR_W = 16, LBIT = 3;
    localparam int F_SEL = 0, F_BASE = 1, F_EFF = 2, F_LIM = 3, F_ATTR = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              long_mode_act = 1'b0;
    logic              sel_we = 0, base_we = 0, lim_we = 0, attr_we = 0;
    logic [3:0]        sel_widx = 0, base_widx = 0, lim_widx = 0, attr_widx = 0;
    logic [SEL_W-1:0]  sel_wdata = 0;
    logic [BASE_W-1:0] base_wdata = 0;
    logic [LIM_W-1:0]  lim_wdata = 0;
    logic [ATTR_W-1:0] attr_wdata = 0;
    logic [3:0]        rd_idx = 0, eff_idx = 0;
    logic [SEL_W-1:0]  rd_sel;
    logic [BASE_W-1:0] rd_base, eff_base;
    logic [LIM_W-1:0]  rd_lim;
    logic [ATTR_W-1:0] rd_attr;

    typedef struct {
        int          idx;
        int          fld;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t sb [$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    seg_regfile #(.SEL_W(SEL_W), .BASE_W(BASE_W), .LIM_W(LIM_W),
                  .ATTR_W(ATTR_W), .LONG_ATTR_BIT(LBIT)) dut (
        .clk(clk), .rst_n(rst_n), .long_mode_act(long_mode_act),
        .sel_we(sel_we), .sel_widx(sel_widx), .sel_wdata(sel_wdata),
        .base_we(base_we), .base_widx(base_widx), .base_wdata(base_wdata),
        .lim_we(lim_we), .lim_widx(lim_widx), .lim_wdata(lim_wdata),
        .attr_we(attr_we), .attr_widx(attr_widx), .attr_wdata(attr_wdata),
        .rd_idx(rd_idx), .rd_sel(rd_sel), .rd_base(rd_base), .rd_lim(rd_lim),
        .rd_attr(rd_attr), .eff_idx(eff_idx), .eff_base(eff_base));

    task automatic cyc_begin();
        @(posedge clk); #1;
        sel_we = 0; base_we = 0; lim_we = 0; attr_we = 0;
    endtask

    task automatic wr_sel(input int i, input logic [SEL_W-1:0] d);
        cyc_begin(); sel_we = 1; sel_widx = 4'(i); sel_wdata = d;
    endtask
    task automatic wr_base(input int i, input logic [BASE_W-1:0] d);
        cyc_begin(); base_we = 1; base_widx = 4'(i); base_wdata = d;
    endtask
    task automatic wr_lim(input int i, input logic [LIM_W-1:0] d);
        cyc_begin(); lim_we = 1; lim_widx = 4'(i); lim_wdata = d;
    endtask
    task automatic wr_attr(input int i, input logic [ATTR_W-1:0] d);
        cyc_begin(); attr_we = 1; attr_widx = 4'(i); attr_wdata = d;
    endtask

    // Queues an expected read for the current cycle; no write unless one was set after cyc_begin.
    task automatic push(input int i, input int f, input logic [63:0] e, input string t);
        item_t it;
        rd_idx = 4'(i); eff_idx = 4'(i);
        it.idx = i; it.fld = f; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask
    task automatic chk(input int i, input int f, input logic [63:0] e, input string t);
        cyc_begin();
        push(i, f, e, t);
    endtask

    // Monitor: compares the queued expectation against the ports at mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = sb.pop_front();
                case (it.fld)
                    F_SEL:   act = 64'(rd_sel);
                    F_BASE:  act = 64'(rd_base);
                    F_EFF:   act = 64'(eff_base);
                    F_LIM:   act = 64'(rd_lim);
                    default: act = 64'(rd_attr);
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s slot %0d field %0d: actual %h expected %h",
                             it.tag, it.idx, it.fld, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R7 reset values
        chk(7,  F_LIM, 64'hFFFF, "R7");
        chk(8,  F_LIM, 64'hFFFF, "R7");
        chk(12, F_LIM, 64'hFFFF, "R7");
        chk(0,  F_LIM, 64'h0, "R7");
        chk(7,  F_SEL, 64'h0, "R7");
        chk(7,  F_ATTR, 64'h0, "R7");
        chk(8,  F_BASE, 64'h0, "R7");
        chk(1,  F_EFF, 64'h0, "R7");

        // R1 indexed writes to every slot
        for (int i = 0; i < 13; i++) wr_sel(i, SEL_W'(16'hA000 + i));
        for (int i = 0; i < 13; i++) chk(i, F_SEL, 64'(16'hA000 + i), "R1");
        wr_lim(3, 32'h0001_2345);
        chk(3, F_LIM, 64'h12345, "R1");
        wr_attr(6, 16'h00F1);
        chk(6, F_ATTR, 64'hF1, "R1");

        // R3 always-copy slots
        wr_base(4, 40'h11_2233_4455);
        chk(4, F_BASE, 64'h11_2233_4455, "R3");
        chk(4, F_EFF,  64'h11_2233_4455, "R3");
        wr_base(11, 40'h7000);
        chk(11, F_EFF, 64'h7000, "R3");
        wr_base(7, 40'h0A_0000_0000);
        chk(7, F_EFF, 64'h0A_0000_0000, "R3");

        // R4 legacy slot outside 64-bit mode
        wr_base(0, 40'h1000_0000);
        chk(0, F_EFF, 64'h1000_0000, "R4");

        // R5 legacy slots hold in 64-bit mode
        long_mode_act = 1'b1;
        wr_attr(1, 16'h0008);
        wr_base(3, 40'h55_0000_0000);
        chk(3, F_BASE, 64'h55_0000_0000, "R5");
        chk(3, F_EFF,  64'h0, "R5");
        wr_base(0, 40'h66);
        chk(0, F_BASE, 64'h66, "R5");
        chk(0, F_EFF,  64'h1000_0000, "R5");

        // R4 either condition clear leaves 64-bit mode
        wr_attr(1, 16'h0000);
        wr_base(2, 40'h77);
        chk(2, F_EFF, 64'h77, "R4");
        wr_attr(1, 16'h0008);
        long_mode_act = 1'b0;
        wr_base(3, 40'h88);
        chk(3, F_EFF, 64'h88, "R4");
        // R4 same-cycle CS attribute write uses the old bit
        long_mode_act = 1'b1;
        wr_attr(1, 16'h0000);
        cyc_begin();
        attr_we = 1; attr_widx = 4'd1; attr_wdata = 16'h0008;
        base_we = 1; base_widx = 4'd0; base_wdata = 40'h99;
        chk(0, F_EFF, 64'h99, "R4");
        wr_base(0, 40'hAA);
        chk(0, F_EFF, 64'h99, "R5");
        chk(0, F_BASE, 64'hAA, "R5");

        // R6 emulation slot
        long_mode_act = 1'b0;
        wr_base(10, 40'h1234);
        chk(10, F_BASE, 64'h1234, "R6");
        chk(10, F_EFF,  64'h0, "R6");

        // R2 flat slot pinned to zero
        wr_base(9, 40'hFFFF);
        chk(9, F_BASE, 64'h0, "R2");
        chk(9, F_EFF,  64'h0, "R2");

        // R8 all four fields of one slot in one cycle
        cyc_begin();
        sel_we = 1;  sel_widx = 4'd5;  sel_wdata = 16'hBEEF;
        base_we = 1; base_widx = 4'd5; base_wdata = 40'h5555;
        lim_we = 1;  lim_widx = 4'd5;  lim_wdata = 32'hCAFE;
        attr_we = 1; attr_widx = 4'd5; attr_wdata = 16'h0042;
        chk(5, F_SEL,  64'hBEEF, "R8");
        chk(5, F_BASE, 64'h5555, "R8");
        chk(5, F_LIM,  64'hCAFE, "R8");
        chk(5, F_ATTR, 64'h42, "R8");
        chk(5, F_EFF,  64'h5555, "R8");

        // R9 read during write returns the old value
        cyc_begin();
        lim_we = 1; lim_widx = 4'd5; lim_wdata = 32'hD00D;
        push(5, F_LIM, 64'hCAFE, "R9");
        chk(5, F_LIM, 64'hD00D, "R9");

        // R10 out-of-range indices
        wr_base(13, 40'h999);
        wr_sel(15, 16'h1111);
        wr_lim(14, 32'h2222);
        chk(13, F_BASE, 64'h0, "R10");
        chk(13, F_EFF,  64'h0, "R10");
        chk(15, F_SEL,  64'h0, "R10");
        chk(14, F_LIM,  64'h0, "R10");
        chk(12, F_BASE, 64'h0, "R10");
        chk(12, F_EFF,  64'h0, "R10");
        chk(12, F_SEL,  64'hA00C, "R10");
        chk(12, F_LIM,  64'hFFFF, "R10");

        cyc_begin();
        @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule